// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block keeps the address and transfer-count state for a four-channel DMA engine. Each channel has a base and a current register for address and for count. A channel can count its address up or down. It can transfer 8-bit or 16-bit units, and it can reload itself when its service finishes. The bus-cycle sequencer outside this block names the channel that is being served and pulses a step input once for each completed transfer. This block then moves the current address and count of that channel to their next values, and it decides whether the service has ended.

Service ends in one of two ways. The count can wrap past zero, or an external end signal can arrive. When service ends, the channel either reloads its current registers from its base registers or masks itself off. In both cases it records a done flag that software can read; reading the flags clears them. The block also outputs three other things: a one-cycle terminal-count pulse, a width flag for the first transfer state, and a request that tells the bus sequencer to re-latch the upper address byte. That request is raised only when the upper byte actually changes.

Top module: `dma_seq`

## Requirements
- R1: While reset is asserted, all four mask bits are set, all done bits are cleared, every channel's current address is 0 and its width is 8-bit, `tc_o` is 0, and `strb_o` is 1. In this state `status_o` reads 8'hF0.
- R2: Configuration writes take effect on the next clock edge. The `cfg_kind_i` codes are:
  - 0: load the base and current address of `cfg_ch_i`.
  - 1: load the base and current count of `cfg_ch_i`.
  - 2: load the mode of `cfg_ch_i`. Bit 0 selects address decrement, bit 1 enables autoinitialize, and bit 2 selects 16-bit width.
  - 3: set the mask bit of `cfg_ch_i` to data bit 0.
  - 4: set memory-to-memory mode to data bit 0.
- R3: A step on the active channel moves its current address by one unit and lowers its current count by 1. A unit is 1 for an 8-bit channel and 2 for a 16-bit channel. The address goes up or down as the mode selects. `addr_o` shows the active channel's current address.
- R4: A step taken while the current count is 0 wraps the count to all ones and counts as a terminal count. `tc_o` pulses high for the one cycle after that edge. A count loaded as N therefore gives N+1 transfers.
- R5: `eop_i` ends service of the active channel in the same way as a terminal count, but it does not pulse `tc_o`.
- R6: When service ends and autoinitialize is enabled, the channel reloads its current address and count from its base registers. Its mask bit stays clear and its done bit is set.
- R7: When service ends and autoinitialize is off, the channel's mask bit is set and its done bit is set. `status_o[3:0]` holds the done bits and `status_o[7:4]` holds the mask bits, both indexed by channel number.
- R8: In memory-to-memory mode, a terminal count on channel 0 gives no `tc_o` pulse, although its done bit is still set. A terminal count on channel 1 does pulse `tc_o`.
- R9: For a 16-bit channel, `addr_o[0]` is 0. While `first_i` is high, `dw_o` is 0 if the active channel is 16-bit and 1 if it is 8-bit. `dw_o` is 1 whenever `first_i` is low.
- R10: `strb_o` is 1 in either of two cases. No step has happened since reset, or the upper byte of `addr_o` differs from the upper byte of the address used by the last step.
- R11: A `stat_rd_i` pulse clears all done bits on the next edge. A service end in the same cycle still sets its own done bit.
- R12: A step or `eop_i` is ignored while the active channel's mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 3 | Which register the write targets |
| cfg_ch_i | input | 2 | Channel the write targets |
| cfg_data_i | input | 16 | Write data |
| act_ch_i | input | 2 | Channel currently being served |
| step_i | input | 1 | One pulse per completed transfer |
| eop_i | input | 1 | External end of service, active high |
| first_i | input | 1 | High during the first transfer state |
| stat_rd_i | input | 1 | Status read, clears the done bits |
| addr_o | output | 16 | Address of the active channel |
| tc_o | output | 1 | Terminal-count pulse |
| status_o | output | 8 | Mask bits [7:4], done bits [3:0] |
| strb_o | output | 1 | Upper-address re-latch request |
| dw_o | output | 1 | Width flag, 0 = 16-bit |

## Verification
Almost every piece of state in this block reaches a port one edge after it is updated. A wrong step size or direction shows on `addr_o` in the very next cycle. A wrong count value stays hidden until the count wraps, and then it appears as a `tc_o` pulse or a done bit at the wrong transfer. A mask or reload mistake shows on `status_o` right away, and it also shows later: a step that should have moved the address leaves it frozen, or the reverse. A stale record of the upper byte shows on `strb_o` at the first step that crosses, or fails to cross, a 256-byte boundary.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [2:0] {
        CFG_ADDR = 3'd0,
        CFG_CNT  = 3'd1,
        CFG_MODE = 3'd2,
        CFG_MASK = 3'd3,
        CFG_XFER = 3'd4
    } cfg_kind_e;

    localparam int unsigned MODE_DEC_BIT  = 0;
    localparam int unsigned MODE_AUTO_BIT = 1;
    localparam int unsigned MODE_WIDE_BIT = 2;
endpackage

// File: rtl/dma_seq_chan.sv
module dma_seq_chan #(
    parameter int unsigned AW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          wr_addr_i,
    input  logic          wr_cnt_i,
    input  logic          wr_mode_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          hit_i,
    input  logic          ext_end_i,
    output logic [AW-1:0] cur_addr_o,
    output logic          wide_o,
    output logic          auto_o,
    output logic          tc_hit_o,
    output logic          end_o
);
    import dma_seq_pkg::*;

    typedef struct packed {
        logic [AW-1:0] base_a;
        logic [AW-1:0] base_c;
        logic [AW-1:0] cur_a;
        logic [AW-1:0] cur_c;
        logic          dec;
        logic          autoi;
        logic          wide;
    } chan_t;

    chan_t ch_d, ch_q;
    logic [AW-1:0] unit;

    always_comb begin
        ch_d     = ch_q;
        unit     = ch_q.wide ? AW'(2) : AW'(1);
        tc_hit_o = hit_i && (ch_q.cur_c == '0);
        end_o    = tc_hit_o || ext_end_i;
        if (hit_i) begin
            ch_d.cur_a = ch_q.dec ? (ch_q.cur_a - unit) : (ch_q.cur_a + unit);
            ch_d.cur_c = ch_q.cur_c - AW'(1);
        end
        if (end_o && ch_q.autoi) begin
            ch_d.cur_a = ch_q.base_a;
            ch_d.cur_c = ch_q.base_c;
        end
        if (wr_addr_i) begin
            ch_d.base_a = wdata_i;
            ch_d.cur_a  = wdata_i;
        end
        if (wr_cnt_i) begin
            ch_d.base_c = wdata_i;
            ch_d.cur_c  = wdata_i;
        end
        if (wr_mode_i) begin
            ch_d.dec   = wdata_i[MODE_DEC_BIT];
            ch_d.autoi = wdata_i[MODE_AUTO_BIT];
            ch_d.wide  = wdata_i[MODE_WIDE_BIT];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ch_q <= '0;
        else       ch_q <= ch_d;
    end

    assign cur_addr_o = ch_q.cur_a;
    assign wide_o     = ch_q.wide;
    assign auto_o     = ch_q.autoi;
endmodule

// File: rtl/dma_seq_hib.sv
module dma_seq_hib #(
    parameter int unsigned HW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          hit_i,
    input  logic [HW-1:0] addr_hi_i,
    output logic          strb_o
);
    typedef struct packed {
        logic [HW-1:0] last_hi;
        logic          vld;
    } hib_t;

    hib_t hb_d, hb_q;

    always_comb begin
        hb_d = hb_q;
        if (hit_i) begin
            hb_d.last_hi = addr_hi_i;
            hb_d.vld     = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) hb_q <= '0;
        else       hb_q <= hb_d;
    end

    assign strb_o = !hb_q.vld || (hb_q.last_hi != addr_hi_i);
endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 16,
    parameter int unsigned HW  = 8,
    parameter int unsigned CW  = $clog2(NCH)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cfg_we_i,
    input  logic [2:0]       cfg_kind_i,
    input  logic [CW-1:0]    cfg_ch_i,
    input  logic [AW-1:0]    cfg_data_i,
    input  logic [CW-1:0]    act_ch_i,
    input  logic             step_i,
    input  logic             eop_i,
    input  logic             first_i,
    input  logic             stat_rd_i,
    output logic [AW-1:0]    addr_o,
    output logic             tc_o,
    output logic [2*NCH-1:0] status_o,
    output logic             strb_o,
    output logic             dw_o
);
    import dma_seq_pkg::*;

    typedef struct packed {
        logic [NCH-1:0] mask;
        logic [NCH-1:0] done;
        logic           tcp;
        logic           m2m;
    } top_t;

    top_t st_d, st_q;

    logic [AW-1:0]  cur_a [NCH];
    logic [NCH-1:0] wide_v, auto_v, tch_v, end_v, hit_v, ext_v;
    logic [NCH-1:0] m2m_excl;
    logic [AW-1:0]  sel_a;
    logic           hit_any;
    cfg_kind_e      kind;

    assign kind = cfg_kind_e'(cfg_kind_i);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign hit_v[g] = step_i && (act_ch_i == CW'(g)) && !st_q.mask[g];
        assign ext_v[g] = eop_i  && (act_ch_i == CW'(g)) && !st_q.mask[g];

        dma_seq_chan #(.AW(AW)) i_chan (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .wr_addr_i  (cfg_we_i && kind == CFG_ADDR && cfg_ch_i == CW'(g)),
            .wr_cnt_i   (cfg_we_i && kind == CFG_CNT  && cfg_ch_i == CW'(g)),
            .wr_mode_i  (cfg_we_i && kind == CFG_MODE && cfg_ch_i == CW'(g)),
            .wdata_i    (cfg_data_i),
            .hit_i      (hit_v[g]),
            .ext_end_i  (ext_v[g]),
            .cur_addr_o (cur_a[g]),
            .wide_o     (wide_v[g]),
            .auto_o     (auto_v[g]),
            .tc_hit_o   (tch_v[g]),
            .end_o      (end_v[g])
        );
    end

    assign hit_any  = |hit_v;
    assign m2m_excl = st_q.m2m ? NCH'(1) : '0;

    always_comb begin
        st_d      = st_q;
        st_d.tcp  = |(tch_v & ~m2m_excl);
        st_d.done = (stat_rd_i ? '0 : st_q.done) | end_v;
        for (int i = 0; i < NCH; i++) begin
            if (end_v[i] && !auto_v[i]) st_d.mask[i] = 1'b1;
        end
        if (cfg_we_i && kind == CFG_MASK) st_d.mask[cfg_ch_i] = cfg_data_i[0];
        if (cfg_we_i && kind == CFG_XFER) st_d.m2m = cfg_data_i[0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.mask <= '1;
            st_q.done <= '0;
            st_q.tcp  <= 1'b0;
            st_q.m2m  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_a    = cur_a[act_ch_i];
    assign addr_o   = wide_v[act_ch_i] ? {sel_a[AW-1:1], 1'b0} : sel_a;
    assign dw_o     = !(first_i && wide_v[act_ch_i]);
    assign tc_o     = st_q.tcp;
    assign status_o = {st_q.mask, st_q.done};

    dma_seq_hib #(.HW(HW)) i_hib (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .hit_i     (hit_any),
        .addr_hi_i (addr_o[AW-1:AW-HW]),
        .strb_o    (strb_o)
    );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 16,
    parameter int unsigned HW  = 8,
    parameter int unsigned CW  = $clog2(NCH)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             cfg_we_i,
    input logic [CW-1:0]    act_ch_i,
    input logic             step_i,
    input logic             eop_i,
    input logic             first_i,
    input logic             stat_rd_i,
    input logic [AW-1:0]    addr_o,
    input logic             tc_o,
    input logic [2*NCH-1:0] status_o,
    input logic             strb_o,
    input logic             dw_o,
    input logic             hit_any
);
    p_tc_after_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        tc_o |-> $past(step_i));

    p_even_wide_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (first_i && !dw_o) |-> !addr_o[0]);

    p_hib_track_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(hit_any) |-> (strb_o == (addr_o[AW-1:AW-HW] != $past(addr_o[AW-1:AW-HW]))));

    p_rd_clears_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (stat_rd_i && !step_i && !eop_i) |=> (status_o[NCH-1:0] == '0));

    p_masked_hold_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && status_o[NCH + act_ch_i] && !cfg_we_i)
        |=> ((act_ch_i != $past(act_ch_i)) || (addr_o == $past(addr_o))));
endmodule

bind dma_seq dma_seq_chk #(.NCH(NCH), .AW(AW), .HW(HW), .CW(CW)) i_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cfg_we_i  (cfg_we_i),
    .act_ch_i  (act_ch_i),
    .step_i    (step_i),
    .eop_i     (eop_i),
    .first_i   (first_i),
    .stat_rd_i (stat_rd_i),
    .addr_o    (addr_o),
    .tc_o      (tc_o),
    .status_o  (status_o),
    .strb_o    (strb_o),
    .dw_o      (dw_o),
    .hit_any   (hit_any)
);

// File: tb/test_dma_seq.sv
`timescale 1ns/1ps
module test_dma_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [2:0]  kind = '0;
    logic [1:0]  cch = '0;
    logic [15:0] cdata = '0;
    logic [1:0]  act = '0;
    logic        step = 1'b0, eop = 1'b0, s1 = 1'b1, rd = 1'b0;
    logic [15:0] addr_o;
    logic        tc_o, strb_o, dw_o;
    logic [7:0]  status_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_seq i_dma_seq (
        .clk_i(clk), .rst_i(rst), .cfg_we_i(we), .cfg_kind_i(kind),
        .cfg_ch_i(cch), .cfg_data_i(cdata), .act_ch_i(act), .step_i(step),
        .eop_i(eop), .first_i(s1), .stat_rd_i(rd), .addr_o(addr_o),
        .tc_o(tc_o), .status_o(status_o), .strb_o(strb_o), .dw_o(dw_o)
    );

    // reference state
    logic [15:0] m_ba [4], m_bc [4], m_ca [4], m_cc [4];
    bit          m_dec [4], m_auto [4], m_wide [4];
    logic [3:0]  m_mask, m_done;
    bit          m_m2m, m_tcp, m_vld;
    logic [7:0]  m_hi;

    function automatic logic [15:0] disp(input int c);
        return m_wide[c] ? {m_ca[c][15:1], 1'b0} : m_ca[c];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0;
            m_dec[i] = 0; m_auto[i] = 0; m_wide[i] = 0;
        end
        m_mask = 4'hF; m_done = 0; m_m2m = 0; m_tcp = 0; m_vld = 0; m_hi = 0;
    endtask

    task automatic model_step();
        int a;
        bit hit, ex, tch, fin;
        logic [3:0] nd;
        a   = int'(act);
        hit = step && !m_mask[a];
        ex  = eop && !m_mask[a];
        tch = 0;
        if (hit) begin
            m_hi  = disp(a)[15:8];
            m_vld = 1;
            tch   = (m_cc[a] == 16'h0);
            m_ca[a] = m_dec[a] ? m_ca[a] - (m_wide[a] ? 16'd2 : 16'd1)
                               : m_ca[a] + (m_wide[a] ? 16'd2 : 16'd1);
            m_cc[a] = m_cc[a] - 16'd1;
        end
        fin   = tch || ex;
        m_tcp = tch && !(m_m2m && a == 0);
        nd = rd ? 4'h0 : m_done;
        if (fin) begin
            nd[a] = 1'b1;
            if (m_auto[a]) begin
                m_ca[a] = m_ba[a]; m_cc[a] = m_bc[a];
            end else begin
                m_mask[a] = 1'b1;
            end
        end
        m_done = nd;
        if (we) begin
            case (kind)
                3'd0: begin m_ba[cch] = cdata; m_ca[cch] = cdata; end
                3'd1: begin m_bc[cch] = cdata; m_cc[cch] = cdata; end
                3'd2: begin m_dec[cch] = cdata[0]; m_auto[cch] = cdata[1]; m_wide[cch] = cdata[2]; end
                3'd3: m_mask[cch] = cdata[0];
                3'd4: m_m2m = cdata[0];
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic compare_all();
        int a;
        a = int'(act);
        chk("R3 addr_o", 32'(addr_o), 32'(disp(a)));
        chk("R7 status_o", 32'(status_o), 32'({m_mask, m_done}));
        chk("R4 tc_o", 32'(tc_o), 32'(m_tcp));
        chk("R10 strb_o", 32'(strb_o), 32'(!m_vld || (m_hi != disp(a)[15:8])));
        chk("R9 dw_o", 32'(dw_o), 32'(!(s1 && m_wide[a])));
    endtask

    // one cycle: drive at negedge, advance model, compare at next negedge
    task automatic go(input bit w, input logic [2:0] k, input logic [1:0] c,
                      input logic [15:0] d, input bit st, input bit ep,
                      input logic [1:0] ac, input bit r, input bit f);
        we = w; kind = k; cch = c; cdata = d; step = st; eop = ep;
        act = ac; rd = r; s1 = f;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [2:0] k, input logic [1:0] c, input logic [15:0] d);
        go(1, k, c, d, 0, 0, act, 0, s1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 status_o", 32'(status_o), 32'h00F0);
        chk("R1 addr_o", 32'(addr_o), 32'h0);
        chk("R1 tc_o", 32'(tc_o), 32'h0);
        chk("R1 dw_o", 32'(dw_o), 32'h1);
        chk("R1 strb_o", 32'(strb_o), 32'h1);
        rst = 1'b0;

        // R2/R3/R4/R10: channel 0 crosses a 256-byte boundary at terminal count
        wr(3'd0, 2'd0, 16'h00FE);
        wr(3'd1, 2'd0, 16'h0001);
        wr(3'd3, 2'd0, 16'h0000);
        chk("R2 address write", 32'(addr_o), 32'h00FE);
        go(0, 0, 0, 0, 1, 0, 2'd0, 0, 1);
        chk("R3 increment", 32'(addr_o), 32'h00FF);
        chk("R10 same high byte", 32'(strb_o), 32'h0);
        go(0, 0, 0, 0, 1, 0, 2'd0, 0, 1);
        chk("R3 increment carry", 32'(addr_o), 32'h0100);
        chk("R4 tc pulse after count 1", 32'(tc_o), 32'h1);
        chk("R10 high byte changed", 32'(strb_o), 32'h1);
        chk("R7 mask and done set", 32'(status_o), 32'h00F1);
        go(0, 0, 0, 0, 0, 0, 2'd0, 1, 1);
        chk("R11 read clears done", 32'(status_o), 32'h00F0);
        chk("R4 pulse is one cycle", 32'(tc_o), 32'h0);

        // R6/R9: 16-bit autoinit channel 1
        act = 2'd1;
        wr(3'd0, 2'd1, 16'h2001);
        wr(3'd1, 2'd1, 16'h0000);
        wr(3'd2, 2'd1, 16'h0006);
        wr(3'd3, 2'd1, 16'h0000);
        go(0, 0, 0, 0, 0, 0, 2'd1, 0, 1);
        chk("R9 even address", 32'(addr_o), 32'h2000);
        chk("R9 width flag 16-bit", 32'(dw_o), 32'h0);
        go(0, 0, 0, 0, 0, 0, 2'd1, 0, 0);
        chk("R9 width flag outside first state", 32'(dw_o), 32'h1);
        go(0, 0, 0, 0, 1, 0, 2'd1, 0, 1);
        chk("R6 tc pulse", 32'(tc_o), 32'h1);
        chk("R6 reload address", 32'(addr_o), 32'h2000);
        chk("R6 mask stays clear", 32'(status_o), 32'h00D2);

        // R8: memory-to-memory terminal counts
        wr(3'd1, 2'd0, 16'h0000);
        wr(3'd3, 2'd0, 16'h0000);
        wr(3'd4, 2'd0, 16'h0001);
        go(0, 0, 0, 0, 1, 0, 2'd0, 0, 1);
        chk("R8 no pulse on channel 0", 32'(tc_o), 32'h0);
        chk("R8 channel 0 done still set", 32'(status_o), 32'h00D3);
        go(0, 0, 0, 0, 1, 0, 2'd1, 0, 1);
        chk("R8 pulse on channel 1", 32'(tc_o), 32'h1);
        wr(3'd4, 2'd0, 16'h0000);

        // R12: masked channel 2 ignores step and eop
        go(0, 0, 0, 0, 1, 1, 2'd2, 0, 1);
        chk("R12 masked address held", 32'(addr_o), 32'h0000);
        chk("R12 masked status held", 32'(status_o), 32'h00D3);

        // R3/R5/R7: decrementing channel 3 ended by eop
        act = 2'd3;
        wr(3'd0, 2'd3, 16'h0100);
        wr(3'd1, 2'd3, 16'h0005);
        wr(3'd2, 2'd3, 16'h0001);
        wr(3'd3, 2'd3, 16'h0000);
        go(0, 0, 0, 0, 1, 0, 2'd3, 0, 1);
        chk("R3 decrement", 32'(addr_o), 32'h00FF);
        chk("R10 high byte differs from last step", 32'(strb_o), 32'h1);
        go(0, 0, 0, 0, 0, 1, 2'd3, 0, 1);
        chk("R5 eop sets mask and done", 32'(status_o), 32'h00DB);
        chk("R5 eop gives no tc pulse", 32'(tc_o), 32'h0);

        // random traffic against the reference
        for (int n = 0; n < 4000; n++) begin
            bit          rw, rs, re, rr, rf;
            logic [2:0]  rk;
            logic [15:0] rdat;
            rw   = ($urandom % 6) == 0;
            rk   = 3'($urandom % 5);
            rdat = 16'($urandom);
            if (rk == 3'd1) rdat = rdat & 16'h0007;
            if (rk == 3'd3) rdat = 16'($urandom % 4 == 0);
            rs = ($urandom % 2) == 0;
            re = ($urandom % 40) == 0;
            rr = ($urandom % 12) == 0;
            rf = ($urandom % 2) == 0;
            go(rw, rk, 2'($urandom), rdat, rs, re, 2'($urandom), rr, rf);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule